// File: doc/BRIEF.md
# Depth-Cascade FIFO Slice

This block is one storage slice of a deep first-in first-out buffer built from several identical slices placed on a ring. All slices share one write strobe, one write data bus and one read strobe. Their read data outputs are OR-ed onto a shared result bus. Each slice tracks two ownership tokens. The write token lets it accept words. The read token lets it return words. A word is stored exactly once, in whichever slice owns the write token at that moment.

Ownership moves around the ring through an active-low expansion pulse. A slice drives its expansion output low for one cycle when it stores into its last physical location, and again when it returns the word held there. The next slice sees that pulse on its expansion input. It takes the write token on the first pulse, the read token on the second, and keeps alternating in that way. The token is usable on the cycle right after the pulse, so a stream of words crosses slice boundaries without a gap.

The operating mode is captured while reset is high. If the expansion input is tied low, the slice runs standalone: it keeps both tokens and its expansion output stays high. The system-level full and empty conditions are the OR of the per-slice active-low flags, taken in their asserted sense.

Top module: `cascade_fifo_slice`

## Requirements
- R1: Reset with `exp_in_n` low selects standalone mode. In this mode the slice always owns both tokens, holds up to DEPTH words in order, `full_n` goes low at DEPTH words, and `exp_out_n` never goes low.
- R2: Reset with `exp_in_n` high selects cascade mode. `first_load_n` low marks the first-load slice, which owns both tokens after reset. Any other slice owns neither. After reset `exp_out_n` and `full_n` are high on every slice, and `empty_n` is low only on the first-load slice.
- R3: A write is stored only when the slice owns the write token and holds fewer than DEPTH words. In all other cases the write is ignored.
- R4: In cascade mode, `exp_out_n` is low during the same cycle as an accepted write into physical location DEPTH-1.
- R5: In cascade mode, `exp_out_n` is low during the same cycle as an accepted read from physical location DEPTH-1.
- R6: In cascade mode, low cycles on `exp_in_n` grant tokens alternately. The first low cycle after reset grants the write token, the next grants the read token, and so on. A grant takes effect on the following cycle.
- R7: A slice gives up its write token on the cycle it writes location DEPTH-1. It gives up its read token on the cycle it reads location DEPTH-1.
- R8: `rd_drive` is high only on a cycle when the slice owns the read token, `rd_en` is high and the slice holds data. `rd_data` is zero on every other cycle, so at most one slice on the ring drives a non-zero word.
- R9: `full_n` is low exactly when the slice owns the write token and holds DEPTH words. `empty_n` is low exactly when the slice owns the read token and holds no word. Across a ring, any asserted `full_n` means every slot is occupied, and any asserted `empty_n` means no word is held.
- R10: Words leave the ring in the order they were accepted, across any number of slice boundaries.
- R11: A write presented while full is rejected even when a read happens in the same cycle. A read presented while empty is rejected even when a write happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode is captured while high |
| exp_in_n | input | 1 | Expansion input, active-low token grant pulse from the previous slice |
| first_load_n | input | 1 | Low marks the first-load slice in cascade mode |
| wr_en | input | 1 | Shared write strobe |
| wr_data | input | WIDTH | Shared write data |
| rd_en | input | 1 | Shared read strobe |
| rd_data | output | WIDTH | Word returned this cycle, zero when not driving |
| rd_drive | output | 1 | High when this slice returns a word this cycle |
| full_n | output | 1 | Active-low full flag of this slice |
| empty_n | output | 1 | Active-low empty flag of this slice |
| exp_out_n | output | 1 | Expansion output, active-low token hand-over pulse |

## Verification
The bench builds a ring of three slices with WIDTH 9 and DEPTH 4, plus one standalone slice with the same parameters. The small depth forces a token hand-over every four words, so a few thousand random cycles cross slice boundaries many times. They also reach the 12-word full point and the empty point repeatedly, including the same-cycle write and read cases at both ends. The standalone instance covers the other mode on the same reset.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        MODE_SOLO   = 2'd0,
        MODE_LEAD   = 2'd1,
        MODE_FOLLOW = 2'd2
    } slice_mode_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } token_s;

    // mode chosen from the expansion input and first-load pin during reset
    function automatic slice_mode_e mode_of(input logic xi_n, input logic fl_n);
        if (!xi_n)
            return MODE_SOLO;
        else if (!fl_n)
            return MODE_LEAD;
        else
            return MODE_FOLLOW;
    endfunction

    function automatic token_s tokens_at_reset(input slice_mode_e m);
        token_s t;
        t.wr = (m != MODE_FOLLOW);
        t.rd = (m != MODE_FOLLOW);
        return t;
    endfunction

endpackage

// File: rtl/cfs_token_ctl.sv
module cfs_token_ctl
    import cfs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   xi_n,
    input  logic   fl_n,
    input  logic   wr_wrap,
    input  logic   rd_wrap,
    output token_s tok,
    output logic   solo,
    output logic   next_is_wr
);

    slice_mode_e mode_q;
    token_s      tok_q, tok_d;
    logic        next_wr_q, next_wr_d;

    // token hand-over: release on own wrap, grant on an expansion pulse
    always_comb begin
        tok_d     = tok_q;
        next_wr_d = next_wr_q;
        if (mode_q != MODE_SOLO) begin
            if (wr_wrap)
                tok_d.wr = 1'b0;
            if (rd_wrap)
                tok_d.rd = 1'b0;
            if (!xi_n) begin
                if (next_wr_q)
                    tok_d.wr = 1'b1;
                else
                    tok_d.rd = 1'b1;
                next_wr_d = ~next_wr_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= mode_of(xi_n, fl_n);
            tok_q     <= tokens_at_reset(mode_of(xi_n, fl_n));
            next_wr_q <= 1'b1;
        end else begin
            tok_q     <= tok_d;
            next_wr_q <= next_wr_d;
        end
    end

    assign tok        = tok_q;
    assign solo       = (mode_q == MODE_SOLO);
    assign next_is_wr = next_wr_q;

endmodule

// File: rtl/cfs_store.sv
module cfs_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_fire,
    input  logic             rd_fire,
    input  logic [WIDTH-1:0] wr_word,
    output logic [WIDTH-1:0] rd_word,
    output logic [CW-1:0]    level,
    output logic             wr_at_last,
    output logic             rd_at_last
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] cells [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    level_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (wr_fire && (wptr == AW'(g)))
                cells[g] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            level_q <= '0;
        end else begin
            if (wr_fire)
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rd_fire)
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({wr_fire, rd_fire})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

    assign rd_word    = cells[rptr];
    assign level      = level_q;
    assign wr_at_last = (wptr == LAST);
    assign rd_at_last = (rptr == LAST);

endmodule

// File: rtl/cfs_port_ctl.sv
module cfs_port_ctl
    import cfs_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input  logic             rst,
    input  token_s           tok,
    input  logic             solo,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [CW-1:0]    level,
    input  logic             wr_at_last,
    input  logic             rd_at_last,
    input  logic [WIDTH-1:0] rd_word,
    output logic             wr_fire,
    output logic             rd_fire,
    output logic             wr_wrap,
    output logic             rd_wrap,
    output logic             full_n,
    output logic             empty_n,
    output logic             exp_out_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_drive
);

    logic has_room, has_data;

    always_comb begin
        has_room  = (level != CW'(DEPTH));
        has_data  = (level != '0);
        wr_fire   = !rst && tok.wr && wr_en && has_room;
        rd_fire   = !rst && tok.rd && rd_en && has_data;
        wr_wrap   = wr_fire && wr_at_last && !solo;
        rd_wrap   = rd_fire && rd_at_last && !solo;
        exp_out_n = !(wr_wrap || rd_wrap);
        full_n    = !(tok.wr && !has_room);
        empty_n   = !(tok.rd && !has_data);
        rd_data   = rd_fire ? rd_word : '0;
        rd_drive  = rd_fire;
    end

endmodule

// File: rtl/cascade_fifo_slice.sv
module cascade_fifo_slice
    import cfs_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             exp_in_n,
    input  logic             first_load_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_drive,
    output logic             full_n,
    output logic             empty_n,
    output logic             exp_out_n
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    token_s           tok;
    logic             solo, next_wr;
    logic             wr_fire, rd_fire, wr_wrap, rd_wrap;
    logic             wr_at_last, rd_at_last;
    logic [CW-1:0]    level;
    logic [WIDTH-1:0] rd_word;

    cfs_token_ctl u_tok (
        .clk        (clk),
        .rst        (rst),
        .xi_n       (exp_in_n),
        .fl_n       (first_load_n),
        .wr_wrap    (wr_wrap),
        .rd_wrap    (rd_wrap),
        .tok        (tok),
        .solo       (solo),
        .next_is_wr (next_wr)
    );

    cfs_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .AW    (AW),
        .CW    (CW)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_fire    (wr_fire),
        .rd_fire    (rd_fire),
        .wr_word    (wr_data),
        .rd_word    (rd_word),
        .level      (level),
        .wr_at_last (wr_at_last),
        .rd_at_last (rd_at_last)
    );

    cfs_port_ctl #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .CW    (CW)
    ) u_port (
        .rst        (rst),
        .tok        (tok),
        .solo       (solo),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .level      (level),
        .wr_at_last (wr_at_last),
        .rd_at_last (rd_at_last),
        .rd_word    (rd_word),
        .wr_fire    (wr_fire),
        .rd_fire    (rd_fire),
        .wr_wrap    (wr_wrap),
        .rd_wrap    (rd_wrap),
        .full_n     (full_n),
        .empty_n    (empty_n),
        .exp_out_n  (exp_out_n),
        .rd_data    (rd_data),
        .rd_drive   (rd_drive)
    );

endmodule

// File: rtl/cascade_fifo_slice_chk.sv
module cascade_fifo_slice_chk #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             exp_in_n,
    input logic             exp_out_n,
    input logic             rd_en,
    input logic             full_n,
    input logic             empty_n,
    input logic             rd_drive,
    input logic [WIDTH-1:0] rd_data,
    input logic             tok_wr,
    input logic             tok_rd,
    input logic             solo,
    input logic             next_wr,
    input logic             wr_wrap,
    input logic             rd_wrap,
    input logic [CW-1:0]    level
);

    a_r2_clean_after_reset: assert property (@(posedge clk)
        rst |=> (full_n && exp_out_n));

    a_r1_solo_quiet_xo: assert property (@(posedge clk) disable iff (rst)
        solo |-> exp_out_n);

    a_r1_solo_owns_both: assert property (@(posedge clk) disable iff (rst)
        solo |-> (tok_wr && tok_rd));

    a_r7_write_token_released: assert property (@(posedge clk) disable iff (rst)
        (wr_wrap && exp_in_n) |=> !tok_wr);

    a_r7_read_token_released: assert property (@(posedge clk) disable iff (rst)
        (rd_wrap && exp_in_n) |=> !tok_rd);

    a_r6_grant_write: assert property (@(posedge clk) disable iff (rst)
        (!exp_in_n && !solo && next_wr) |=> tok_wr);

    a_r6_grant_read: assert property (@(posedge clk) disable iff (rst)
        (!exp_in_n && !solo && !next_wr) |=> tok_rd);

    a_r11_full_persists: assert property (@(posedge clk) disable iff (rst)
        (!full_n && !rd_en) |=> !full_n);

    a_r8_drive_has_data: assert property (@(posedge clk) disable iff (rst)
        rd_drive |-> (level != '0));

    a_r9_empty_never_drives: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> !rd_drive);

    a_r8_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_drive |-> (rd_data == '0));

endmodule

bind cascade_fifo_slice cascade_fifo_slice_chk #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH),
    .CW    (CW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .exp_in_n  (exp_in_n),
    .exp_out_n (exp_out_n),
    .rd_en     (rd_en),
    .full_n    (full_n),
    .empty_n   (empty_n),
    .rd_drive  (rd_drive),
    .rd_data   (rd_data),
    .tok_wr    (tok.wr),
    .tok_rd    (tok.rd),
    .solo      (solo),
    .next_wr   (next_wr),
    .wr_wrap   (wr_wrap),
    .rd_wrap   (rd_wrap),
    .level     (level)
);

// File: tb/cascade_fifo_slice_bench.sv
module cascade_fifo_slice_bench;

    localparam int W   = 9;
    localparam int D   = 4;
    localparam int N   = 3;
    localparam int CAP = N * D;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst;
    logic         wr_en, rd_en;
    logic [W-1:0] din;
    logic [N-1:0] xo_n, full_n, empty_n, drv;
    logic [W-1:0] dq [N];
    logic [W-1:0] bus;

    logic         s_wr, s_rd;
    logic [W-1:0] s_din, s_q;
    logic         s_drv, s_full_n, s_empty_n, s_xo_n;

    int n_vec = 0;
    int n_bad = 0;
    int q[$];
    int sq[$];
    int wi = 0;
    int ri = 0;

    for (genvar k = 0; k < N; k++) begin : g_ring
        localparam int PREV = (k + N - 1) % N;
        cascade_fifo_slice #(.WIDTH(W), .DEPTH(D)) u_ring (
            .clk          (clk),
            .rst          (rst),
            .exp_in_n     (xo_n[PREV]),
            .first_load_n ((k == 0) ? 1'b0 : 1'b1),
            .wr_en        (wr_en),
            .wr_data      (din),
            .rd_en        (rd_en),
            .rd_data      (dq[k]),
            .rd_drive     (drv[k]),
            .full_n       (full_n[k]),
            .empty_n      (empty_n[k]),
            .exp_out_n    (xo_n[k])
        );
    end

    assign bus = dq[0] | dq[1] | dq[2];

    cascade_fifo_slice #(.WIDTH(W), .DEPTH(D)) u_cascade_fifo_slice (
        .clk          (clk),
        .rst          (rst),
        .exp_in_n     (1'b0),
        .first_load_n (1'b1),
        .wr_en        (s_wr),
        .wr_data      (s_din),
        .rd_en        (s_rd),
        .rd_data      (s_q),
        .rd_drive     (s_drv),
        .full_n       (s_full_n),
        .empty_n      (s_empty_n),
        .exp_out_n    (s_xo_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_xo_low(input int s, input bit wacc, input bit racc);
        return (wacc && (wi % D == D - 1) && ((wi / D) % N == s)) ||
               (racc && (ri % D == D - 1) && ((ri / D) % N == s));
    endfunction

    task automatic ring_step(input bit we, input bit re, input logic [W-1:0] d);
        bit wacc, racc;
        @(negedge clk);
        wr_en = we;
        rd_en = re;
        din   = d;
        #2;
        wacc = we && (q.size() < CAP);
        racc = re && (q.size() > 0);
        chk((|(~full_n)) == (q.size() == CAP), "R9/R11 full", int'(|(~full_n)), int'(q.size() == CAP));
        chk((|(~empty_n)) == (q.size() == 0), "R9/R11 empty", int'(|(~empty_n)), int'(q.size() == 0));
        for (int s = 0; s < N; s++) begin
            chk(xo_n[s] == !exp_xo_low(s, wacc, racc), "R4/R5/R6/R7 xo",
                int'(xo_n[s]), int'(!exp_xo_low(s, wacc, racc)));
            chk(drv[s] == (racc && ((ri / D) % N == s)), "R8 drive",
                int'(drv[s]), int'(racc && ((ri / D) % N == s)));
        end
        if (racc)
            chk(int'(bus) == q[0], "R10/R3 order", int'(bus), q[0]);
        else
            chk(bus == '0, "R8 idle bus", int'(bus), 0);
        @(posedge clk);
        if (racc) begin
            void'(q.pop_front());
            ri++;
        end
        if (wacc) begin
            q.push_back(int'(d));
            wi++;
        end
    endtask

    task automatic solo_step(input bit we, input bit re, input logic [W-1:0] d);
        bit wacc, racc;
        @(negedge clk);
        s_wr  = we;
        s_rd  = re;
        s_din = d;
        #2;
        wacc = we && (sq.size() < D);
        racc = re && (sq.size() > 0);
        chk(s_xo_n == 1'b1, "R1 solo xo", int'(s_xo_n), 1);
        chk(s_full_n == (sq.size() != D), "R1 solo full", int'(s_full_n), int'(sq.size() != D));
        chk(s_empty_n == (sq.size() != 0), "R1 solo empty", int'(s_empty_n), int'(sq.size() != 0));
        if (racc)
            chk(int'(s_q) == sq[0], "R1 solo order", int'(s_q), sq[0]);
        else
            chk(s_drv == 1'b0, "R1 solo idle", int'(s_drv), 0);
        @(posedge clk);
        if (racc)
            void'(sq.pop_front());
        if (wacc)
            sq.push_back(int'(d));
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1;
        wr_en = 1'b0; rd_en = 1'b0; din = '0;
        s_wr = 1'b0; s_rd = 1'b0; s_din = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R2: state right after reset
        chk(xo_n == 3'b111, "R2 xo high", int'(xo_n), 7);
        chk(full_n == 3'b111, "R2 full_n", int'(full_n), 7);
        chk(empty_n == 3'b110, "R2 empty_n", int'(empty_n), 6);
        chk(drv == 3'b000, "R2 drive", int'(drv), 0);
        chk(s_empty_n == 1'b0 && s_full_n == 1'b1, "R1 solo reset", int'({s_empty_n, s_full_n}), 1);

        // R1: standalone fill, overfill, drain, over-read
        for (int i = 0; i < D + 1; i++) solo_step(1'b1, 1'b0, W'(9'h40 + i));
        solo_step(1'b1, 1'b1, 9'h1AA);
        for (int i = 0; i < D + 1; i++) solo_step(1'b0, 1'b1, '0);

        // R3/R4/R10/R11: fill the ring to the full point and beyond
        for (int i = 0; i < CAP + 2; i++) ring_step(1'b1, 1'b0, W'(i + 1));
        ring_step(1'b1, 1'b1, 9'h155);
        // R5/R11: drain past empty, then write and read together on empty
        for (int i = 0; i < CAP + 2; i++) ring_step(1'b0, 1'b1, '0);
        ring_step(1'b1, 1'b1, 9'h0F0);
        ring_step(1'b0, 1'b1, '0);

        // R6/R9/R10: random traffic with alternating bias
        for (int ph = 0; ph < 6; ph++) begin
            for (int c = 0; c < 700; c++) begin
                int pw;
                int pr;
                pw = (ph % 2 == 0) ? 75 : 35;
                pr = (ph % 2 == 0) ? 35 : 75;
                ring_step($urandom_range(0, 99) < pw, $urandom_range(0, 99) < pr,
                          W'($urandom_range(0, 511)));
            end
        end
        for (int i = 0; i < CAP + 1; i++) ring_step(1'b0, 1'b1, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule